// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block sits between a set of interrupt request lines and the CPU. It picks one winning interrupt cause on every clock. One input is a non-maskable request. The others are maskable request lines, and each maskable line has its own programmable 5-bit priority level register. The block reports the winner to the CPU as a valid flag, the winner's level, its interrupt number and the offset of its entry in the vector table.

Software sets the priority of each maskable source through a simple write port. The port takes a strobe, a source index and a level value. A level of 31 shuts a source out of arbitration, and every register starts at that value after reset. The non-maskable request beats every other cause. Among the maskable sources, the numerically smallest level wins. When two eligible sources share that level, the source with the smaller interrupt number wins.

The result is registered, so the CPU sees a stable winner one clock after the inputs change. The vector offset lets the CPU form the handler address. It adds the offset to a table base of 0x000FFC00, so interrupt 15 lands at 0x000FFFC0.

Top module: `irq_resolver`

## Requirements
- R1: While `nmi_req` is high, the next registered result is valid with number 15 and level 15, whatever the maskable requests and levels are.
- R2: A maskable source whose level register holds 31 never wins, even when its request line is high. A valid result never reports level 31.
- R3: Among maskable sources with the request high and a level below 31, the one with the numerically smallest level wins.
- R4: When several eligible sources share the smallest level, the one with the smallest interrupt number wins.
- R5: Maskable source k (bit k of `irq_req`) has interrupt number 16+k and is ranked by level register k.
- R6: For a valid result with number n, `int_vec_off` equals 0x3FC minus 4·n, so 15 gives 0x3C0 and 16 gives 0x3BC. When the result is not valid, it reads 0.
- R7: During and after reset, every level register holds 31 and the outputs read valid 0, level 31, number 0 and offset 0.
- R8: With `nmi_req` low and no eligible maskable request, the outputs read valid 0, level 31, number 0 and offset 0.
- R9: The outputs are registered. A change on `nmi_req` or `irq_req` shows at the outputs after exactly one rising clock edge, and not before.
- R10: A level write is stored on the clock edge where `lvl_wr_en` is high and takes part in arbitration from the next cycle. The result therefore changes one edge after the storing edge. A write whose index is 12 or above changes no level register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 12 | Maskable request lines; bit k is source k |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_idx | input | 4 | Index of the level register to write |
| lvl_wr_data | input | 5 | Level value to write |
| int_valid | output | 1 | A cause has been selected |
| int_level | output | 5 | Level of the winner (31 when none) |
| int_num | output | 6 | Interrupt number of the winner (0 when none) |
| int_vec_off | output | 10 | Vector table offset of the winner (0 when none) |

## Verification
Each directed pattern is built to separate one ordering rule from the others.

- **Single source:** shows that bit k maps to number 16+k and to the matching offset.
- **Distinct levels:** all sources request at different levels, and the winner is not the lowest-numbered source. This separates "smallest level wins" from a fixed order by position.
- **Tie:** two sources request at the same minimum level, which exposes a tie broken toward the larger number.
- **Level 31:** requests at level 31, and out-of-range writes, show that inhibited or ignored state never changes the outcome.
- **Non-maskable request:** raised on top of strong maskable requests, it must still win.
- **Timing:** a request change sampled just after an edge, and a level write, pin down the one-cycle result latency.
- **Random sweep:** mixes all of the above against a model of the rules.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int LVL_W     = 5;
    localparam int NUM_W     = 6;
    localparam int VEC_W     = 10;
    localparam logic [LVL_W-1:0] LVL_OFF  = 5'd31;
    localparam logic [LVL_W-1:0] NMI_LVL  = 5'd15;
    localparam logic [NUM_W-1:0] NMI_NUM  = 6'd15;
    localparam int FIRST_NUM = 16;
    localparam logic [VEC_W-1:0] VEC_TOP  = 10'h3FC;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
        logic [NUM_W-1:0] num;
    } cand_t;

    localparam cand_t CAND_NONE = '{vld: 1'b0, lvl: LVL_OFF, num: '0};

    // true when candidate a outranks b (a earlier in scan order on ties)
    function automatic logic outranks(cand_t a, cand_t b);
        return a.vld && (!b.vld || (a.lvl < b.lvl));
    endfunction

    function automatic logic [VEC_W-1:0] vec_offset(logic [NUM_W-1:0] n);
        return VEC_TOP - {2'b00, n, 2'b00};
    endfunction

endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
    import irq_pkg::*;
#(
    parameter int N_SRC = 12,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [LVL_W-1:0]            wr_data,
    output logic [N_SRC-1:0][LVL_W-1:0] levels
);

    for (genvar k = 0; k < N_SRC; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                levels[k] <= LVL_OFF;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                levels[k] <= wr_data;
            end
        end
    end

    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    assert_oob_ignored_R10: assert property (@(posedge clk) disable iff (rst || !live_q)
        $past(wr_en && (32'(wr_idx) >= N_SRC)) |-> (levels == $past(levels)));

endmodule

// File: rtl/irq_min_select.sv
module irq_min_select
    import irq_pkg::*;
#(
    parameter int N_SRC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  cand_t [N_SRC-1:0] cands,
    output cand_t             winner
);

    always_comb begin
        winner = CAND_NONE;
        for (int k = 0; k < N_SRC; k++) begin
            if (outranks(cands[k], winner)) winner = cands[k];
        end
    end

    for (genvar k = 0; k < N_SRC; k++) begin : g_chk
        assert_lowest_level_R3: assert property (@(posedge clk) disable iff (rst)
            cands[k].vld |-> (winner.vld && winner.lvl <= cands[k].lvl));
        assert_tie_smallest_R4: assert property (@(posedge clk) disable iff (rst)
            (cands[k].vld && winner.lvl == cands[k].lvl) |-> (winner.num <= cands[k].num));
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_pkg::*;
#(
    parameter int N_SRC = 12,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_req,
    input  logic [N_SRC-1:0]   irq_req,
    input  logic               lvl_wr_en,
    input  logic [IDX_W-1:0]   lvl_wr_idx,
    input  logic [LVL_W-1:0]   lvl_wr_data,
    output logic               int_valid,
    output logic [LVL_W-1:0]   int_level,
    output logic [NUM_W-1:0]   int_num,
    output logic [VEC_W-1:0]   int_vec_off
);

    logic [N_SRC-1:0][LVL_W-1:0] levels;
    cand_t [N_SRC-1:0]           cands;
    cand_t                       mask_win;
    cand_t                       final_win;
    logic [N_SRC-1:0]            eligible;

    irq_level_regs #(.N_SRC(N_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lvl_wr_en),
        .wr_idx  (lvl_wr_idx),
        .wr_data (lvl_wr_data),
        .levels  (levels)
    );

    for (genvar k = 0; k < N_SRC; k++) begin : g_cand
        assign eligible[k]  = irq_req[k] && (levels[k] != LVL_OFF);
        assign cands[k].vld = eligible[k];
        assign cands[k].lvl = levels[k];
        assign cands[k].num = NUM_W'(FIRST_NUM + k);
    end

    irq_min_select #(.N_SRC(N_SRC)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .cands  (cands),
        .winner (mask_win)
    );

    always_comb begin
        if (nmi_req) final_win = '{vld: 1'b1, lvl: NMI_LVL, num: NMI_NUM};
        else         final_win = mask_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_valid   <= 1'b0;
            int_level   <= LVL_OFF;
            int_num     <= '0;
            int_vec_off <= '0;
        end else begin
            int_valid   <= final_win.vld;
            int_level   <= final_win.vld ? final_win.lvl : LVL_OFF;
            int_num     <= final_win.vld ? final_win.num : '0;
            int_vec_off <= final_win.vld ? vec_offset(final_win.num) : '0;
        end
    end

    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    assert_nmi_wins_R1: assert property (@(posedge clk) disable iff (rst || !live_q)
        $past(nmi_req) |-> (int_valid && int_num == NMI_NUM && int_level == NMI_LVL));

    assert_no_off_level_R2: assert property (@(posedge clk) disable iff (rst)
        int_valid |-> (int_level != LVL_OFF));

    assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (rst || !live_q)
        (!$past(nmi_req) && !$past(|eligible)) |->
            (!int_valid && int_level == LVL_OFF && int_num == '0 && int_vec_off == '0));

endmodule

// File: tb/irq_resolver_tb.sv
`timescale 1ns/1ps
module irq_resolver_tb;

    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        nmi_req;
    logic [N-1:0] irq_req;
    logic        lvl_wr_en;
    logic [3:0]  lvl_wr_idx;
    logic [4:0]  lvl_wr_data;
    logic        int_valid;
    logic [4:0]  int_level;
    logic [5:0]  int_num;
    logic [9:0]  int_vec_off;

    int checks = 0;
    int errors = 0;
    int shadow [N];

    always #4 clk = ~clk;

    irq_resolver #(.N_SRC(N)) u_dut (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_idx(lvl_wr_idx), .lvl_wr_data(lvl_wr_data),
        .int_valid(int_valid), .int_level(int_level), .int_num(int_num),
        .int_vec_off(int_vec_off)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(string tag, int ev, int el, int en, int eo);
        chk({tag, " valid"},  int'(int_valid),   ev);
        chk({tag, " level"},  int'(int_level),   el);
        chk({tag, " number"}, int'(int_num),     en);
        chk({tag, " offset"}, int'(int_vec_off), eo);
    endtask

    // Reference from the requirements
    task automatic model(input logic nmi, input logic [N-1:0] req,
                         output int ev, output int el, output int en, output int eo);
        int best = -1;
        if (nmi) begin
            ev = 1; el = 15; en = 15; eo = 'h3FC - 4 * 15;
            return;
        end
        for (int k = 0; k < N; k++) begin
            if (req[k] && shadow[k] != 31 && (best < 0 || shadow[k] < shadow[best])) best = k;
        end
        if (best < 0) begin
            ev = 0; el = 31; en = 0; eo = 0;
        end else begin
            ev = 1; el = shadow[best]; en = 16 + best; eo = 'h3FC - 4 * (16 + best);
        end
    endtask

    task automatic apply(input logic nmi, input logic [N-1:0] req);
        @(negedge clk);
        nmi_req = nmi;
        irq_req = req;
        @(negedge clk);
    endtask

    task automatic apply_and_model(string tag, input logic nmi, input logic [N-1:0] req);
        int ev, el, en, eo;
        apply(nmi, req);
        model(nmi, req, ev, el, en, eo);
        chk_out(tag, ev, el, en, eo);
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        lvl_wr_en   = 1'b1;
        lvl_wr_idx  = 4'(idx);
        lvl_wr_data = 5'(val);
        if (idx < N) shadow[idx] = val;
        @(negedge clk);
        lvl_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk_out("R7 reset outputs", 0, 31, 0, 0);
        apply(1'b0, '1);
        chk_out("R7 levels start at 31 / R2 inhibited", 0, 31, 0, 0);
        apply(1'b0, '0);
        chk_out("R8 no request", 0, 31, 0, 0);
    endtask

    task automatic t_single;
        wr(5, 10);
        apply(1'b0, N'(1) << 5);
        chk_out("R5 R6 single source 5", 1, 10, 21, 'h3A8);
        wr(0, 7);
        apply(1'b0, N'(1));
        chk_out("R6 source 0 offset 0x3BC", 1, 7, 16, 'h3BC);
        apply(1'b0, N'(1) << 3);
        chk_out("R2 R8 source at level 31", 0, 31, 0, 0);
    endtask

    task automatic t_lowest;
        for (int k = 0; k < N; k++) wr(k, 20 - k);
        wr(11, 30);
        apply_and_model("R3 distinct levels all request", 1'b0, '1);
        chk("R3 winner is source 10", int'(int_num), 26);
        apply_and_model("R3 subset request", 1'b0, 12'b0000_0011_0101);
    endtask

    task automatic t_tie;
        wr(4, 2);
        wr(9, 2);
        apply_and_model("R4 tie low pair", 1'b0, '1);
        chk("R4 tie picks number 20", int'(int_num), 20);
        apply_and_model("R4 tie higher only", 1'b0, 12'b0010_0000_0000);
    endtask

    task automatic t_nmi;
        wr(2, 0);
        apply(1'b1, '1);
        chk_out("R1 R6 NMI over level 0", 1, 15, 15, 'h3C0);
        apply(1'b1, '0);
        chk_out("R1 NMI alone", 1, 15, 15, 'h3C0);
    endtask

    task automatic t_latency;
        int ev, el, en, eo;
        apply(1'b0, N'(1) << 2);
        @(posedge clk); #1;
        irq_req = N'(1) << 9;
        #1;
        chk("R9 old result held before edge", int'(int_num), 18);
        @(posedge clk); #2;
        model(1'b0, N'(1) << 9, ev, el, en, eo);
        chk_out("R9 new result after one edge", ev, el, en, eo);
    endtask

    task automatic t_write;
        wr(6, 12);
        wr(7, 12);
        apply(1'b0, 12'b0000_1100_0000);
        chk("R10 pre-write winner", int'(int_num), 22);
        @(negedge clk);
        lvl_wr_en = 1'b1; lvl_wr_idx = 4'd7; lvl_wr_data = 5'd3;
        @(posedge clk); #2;
        lvl_wr_en = 1'b0;
        shadow[7] = 3;
        chk("R10 write not yet in result", int'(int_num), 22);
        @(posedge clk); #2;
        chk_out("R10 write seen next cycle", 1, 3, 23, 'h3FC - 4 * 23);
        for (int idx = 12; idx < 16; idx++) wr(idx, 0);
        apply_and_model("R10 out-of-range writes ignored", 1'b0, '1);
        chk("R10 winner still number 18", int'(int_num), 18);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 150; i++) begin
            if ((i % 3) == 0) wr(int'($urandom_range(N - 1)), int'($urandom_range(31)));
            apply_and_model("R3 R4 sweep", ($urandom_range(7) == 0), N'($urandom));
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) shadow[k] = 31;
        rst = 1'b1; nmi_req = 1'b0; irq_req = '0;
        lvl_wr_en = 1'b0; lvl_wr_idx = '0; lvl_wr_data = '0;
        repeat (3) @(negedge clk);
        t_reset_during();
        rst = 1'b0;
        t_reset();
        t_single();
        t_lowest();
        t_tie();
        t_nmi();
        t_latency();
        t_write();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic t_reset_during;
        chk_out("R7 outputs in reset", 0, 31, 0, 0);
    endtask

endmodule